// File: doc/BRIEF.md
# Load/Store Address Generator with Narrow-Load Formatting

This block sits in the memory stage of a small processor pipeline. Each cycle it takes a base register value and an offset and forms the address for a load or store. The offset can be a zero-extended immediate, an index register, or an index register shifted left by a small amount, and it is either added to the base or subtracted from it. The indexing mode picks which result goes to memory and which goes back to the base register. Offset mode changes no register. Pre-indexed mode uses the updated base as the address and also writes it back. Post-indexed mode uses the old base as the address and writes the updated value back.

In the same cycle, the block formats the 32-bit word returned by memory for the addressed location. Lane selection uses the low bits of the computed address. A byte or halfword is taken out of the word and then zero-extended or sign-extended to 32 bits. The lane order is little-endian by default. A big-endian order is chosen with a pin that is sampled only while reset is held, so the byte order stays fixed for the whole run.

Top module: `ldst_agu`

## Requirements
- R1: With mode 0 (or the unused code 3), effAddr equals base plus or minus the offset, and wbEn is 0.
- R2: With mode 1 (pre-indexed), effAddr equals base plus or minus the offset, wbEn is 1, and wbVal equals effAddr.
- R3: With mode 2 (post-indexed), effAddr equals base unchanged, wbEn is 1, and wbVal equals base plus or minus the offset.
- R4: The offset source is set by offSel. A value of 0 uses immOff zero-extended, 1 uses idxReg, and 2 or 3 use idxReg shifted left by shAmt. dirUp=1 adds the offset and dirUp=0 subtracts it, with all arithmetic modulo 2^ADDR_W.
- R5: With size 0 (byte) and signedLd=0, ldData[7:0] is the addressed byte and ldData[31:8] is zero. In little-endian order, byte k=effAddr[1:0] is rdWord[8k+7:8k].
- R6: With signedLd=1, byte loads copy bit 7 into ldData[31:8], and halfword loads copy bit 15 into ldData[31:16].
- R7: With size 1 (halfword), effAddr[0] is ignored. In little-endian order, effAddr[1]=h selects rdWord[16h+15:16h]. Unsigned halfword loads clear ldData[31:16].
- R8: In big-endian order, byte k is rdWord[8(3-k)+7:8(3-k)] and halfword h is rdWord[16(1-h)+15:16(1-h)]. bigEndPin selects big-endian when it is 1. It is sampled at each clock edge while rstN is low, and changes to it after rstN goes high have no effect.
- R9: With size 2 or 3 (word), ldData equals rdWord for any address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset; byte order is sampled while it is low |
| bigEndPin | input | 1 | 1 selects big-endian lane order (sampled in reset only) |
| base | input | ADDR_W | Base register value |
| immOff | input | IMM_W | Immediate offset, zero-extended |
| idxReg | input | ADDR_W | Index register value |
| offSel | input | 2 | Offset source: 0 immediate, 1 index, 2/3 shifted index |
| shAmt | input | SH_W | Left shift applied to the index register |
| mode | input | 2 | 0 offset, 1 pre-indexed, 2 post-indexed, 3 as offset |
| dirUp | input | 1 | 1 add offset, 0 subtract |
| size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| signedLd | input | 1 | Sign-extend narrow loads |
| rdWord | input | 32 | Word returned from memory |
| effAddr | output | ADDR_W | Effective address |
| wbEn | output | 1 | Base writeback enable |
| wbVal | output | ADDR_W | Base writeback value |
| ldData | output | 32 | Formatted load data |

## Verification
The bench builds the block with ADDR_W=10, IMM_W=4 and SH_W=2. At these sizes every immediate, every shift amount, every offset source, both directions and all four mode codes can be swept against several bases. The sweep includes bases near zero and near the top of the address space, so wrap-around in both directions is covered. The load path is swept over every low address combination, every size and both signedness settings, using words whose lanes have the sign bit set and clear. This is done once after a little-endian reset and once after a big-endian reset, and the pin is toggled after each reset to show that the byte order stays latched.

// File: rtl/agu_pkg.sv
package agu_pkg;

  localparam int WORD_W    = 32;
  localparam int BYTE_LANES = WORD_W / 8;
  localparam int HALF_LANES = WORD_W / 16;

  typedef enum logic [1:0] {
    IDX_OFFSET = 2'd0,
    IDX_PRE    = 2'd1,
    IDX_POST   = 2'd2,
    IDX_SPARE  = 2'd3
  } idxMode_e;

  typedef enum logic [1:0] {
    W_BYTE = 2'd0,
    W_HALF = 2'd1,
    W_WORD = 2'd2
  } ldWidth_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     eaUsesSum;
    logic     wbEn;
    logic     subtract;
    logic     offFromReg;
    logic     offShifted;
    logic     laneBig;
    logic     extSigned;
    ldWidth_e width;
  } aguStrobe_t;

endpackage

// File: rtl/agu_ctrl.sv
module agu_ctrl
  import agu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       bigEndPin,
  input  logic [1:0] mode,
  input  logic       dirUp,
  input  logic [1:0] offSel,
  input  logic [1:0] size,
  input  logic       signedLd,
  output aguStrobe_t strobe
);

  logic     bigMode;
  idxMode_e idxMode;

  // byte order follows the pin only while reset is held
  always_ff @(posedge clk) begin
    if (!rstN) bigMode <= bigEndPin;
  end

  assign idxMode = idxMode_e'(mode);

  always_comb begin
    strobe            = '0;
    strobe.eaUsesSum  = (idxMode != IDX_POST);
    strobe.wbEn       = (idxMode == IDX_PRE) || (idxMode == IDX_POST);
    strobe.subtract   = !dirUp;
    strobe.offFromReg = (offSel != 2'd0);
    strobe.offShifted = offSel[1];
    strobe.laneBig    = bigMode;
    strobe.extSigned  = signedLd;
    unique case (size)
      2'd0:    strobe.width = W_BYTE;
      2'd1:    strobe.width = W_HALF;
      default: strobe.width = W_WORD;
    endcase
  end

  // R8: order is frozen once out of reset
  assert_endian_locked_R8: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> $stable(bigMode));

endmodule

// File: rtl/agu_datapath.sv
module agu_datapath
  import agu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 12,
  parameter int SH_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  aguStrobe_t        strobe,
  input  logic [ADDR_W-1:0] base,
  input  logic [IMM_W-1:0]  immOff,
  input  logic [ADDR_W-1:0] idxReg,
  input  logic [SH_W-1:0]   shAmt,
  input  logic [WORD_W-1:0] rdWord,
  output logic [ADDR_W-1:0] effAddr,
  output logic              wbEn,
  output logic [ADDR_W-1:0] wbVal,
  output logic [WORD_W-1:0] ldData
);

  localparam int BIDX_W = $clog2(BYTE_LANES);
  localparam int HIDX_W = (HALF_LANES > 1) ? $clog2(HALF_LANES) : 1;

  logic [ADDR_W-1:0] immExt, regOff, offVal, sum;
  logic [BIDX_W-1:0] byteIdx;
  logic [HIDX_W-1:0] halfIdx;
  logic [7:0]        byteLane [BYTE_LANES];
  logic [15:0]       halfLane [HALF_LANES];
  logic [7:0]        byteSel;
  logic [15:0]       halfSel;

  // offset source and adder
  assign immExt  = ADDR_W'(immOff);
  assign regOff  = strobe.offShifted ? (idxReg << shAmt) : idxReg;
  assign offVal  = strobe.offFromReg ? regOff : immExt;
  assign sum     = strobe.subtract ? (base - offVal) : (base + offVal);
  assign effAddr = strobe.eaUsesSum ? sum : base;
  assign wbVal   = sum;
  assign wbEn    = strobe.wbEn;

  // lane split of the returned word
  for (genvar g = 0; g < BYTE_LANES; g++) begin : gByte
    assign byteLane[g] = rdWord[8*g +: 8];
  end
  for (genvar g = 0; g < HALF_LANES; g++) begin : gHalf
    assign halfLane[g] = rdWord[16*g +: 16];
  end

  // big-endian mirrors the lane index
  assign byteIdx = effAddr[BIDX_W-1:0] ^ {BIDX_W{strobe.laneBig}};
  assign halfIdx = effAddr[BIDX_W-1 -: HIDX_W] ^ {HIDX_W{strobe.laneBig}};
  assign byteSel = byteLane[byteIdx];
  assign halfSel = halfLane[halfIdx];

  always_comb begin
    unique case (strobe.width)
      W_BYTE:  ldData = {{(WORD_W-8){strobe.extSigned & byteSel[7]}}, byteSel};
      W_HALF:  ldData = {{(WORD_W-16){strobe.extSigned & halfSel[15]}}, halfSel};
      default: ldData = rdWord;
    endcase
  end

  // R5: unsigned byte leaves the upper bits clear
  assert_byte_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.width == W_BYTE && !strobe.extSigned) |-> (ldData[WORD_W-1:8] == '0));

  // R6: signed byte replicates its top bit
  assert_byte_sign_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.width == W_BYTE && strobe.extSigned) |->
      (ldData[WORD_W-1:8] == {(WORD_W-8){ldData[7]}}));

endmodule

// File: rtl/ldst_agu.sv
module ldst_agu
  import agu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 12,
  parameter int SH_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bigEndPin,
  input  logic [ADDR_W-1:0] base,
  input  logic [IMM_W-1:0]  immOff,
  input  logic [ADDR_W-1:0] idxReg,
  input  logic [1:0]        offSel,
  input  logic [SH_W-1:0]   shAmt,
  input  logic [1:0]        mode,
  input  logic              dirUp,
  input  logic [1:0]        size,
  input  logic              signedLd,
  input  logic [31:0]       rdWord,
  output logic [ADDR_W-1:0] effAddr,
  output logic              wbEn,
  output logic [ADDR_W-1:0] wbVal,
  output logic [31:0]       ldData
);

  aguStrobe_t strobe;

  agu_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .bigEndPin(bigEndPin), .mode(mode), .dirUp(dirUp),
    .offSel(offSel), .size(size), .signedLd(signedLd), .strobe(strobe)
  );

  agu_datapath #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .SH_W(SH_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .base(base), .immOff(immOff),
    .idxReg(idxReg), .shAmt(shAmt), .rdWord(rdWord), .effAddr(effAddr),
    .wbEn(wbEn), .wbVal(wbVal), .ldData(ldData)
  );

  // R1: offset mode never writes back
  assert_offset_no_wb_R1: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd0 || mode == 2'd3) |-> !wbEn);

  // R2: pre-indexed writes back the address it used
  assert_pre_wb_match_R2: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd1) |-> (wbEn && wbVal == effAddr));

  // R3: post-indexed accesses at the old base
  assert_post_base_R3: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd2) |-> (wbEn && effAddr == base));

endmodule

// File: tb/sim_ldst_agu.sv
module sim_ldst_agu;

  localparam int AW = 10;
  localparam int IW = 4;
  localparam int SW = 2;
  localparam int MASK = (1 << AW) - 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          bigEndPin = 1'b0;
  logic [AW-1:0] base = '0;
  logic [IW-1:0] immOff = '0;
  logic [AW-1:0] idxReg = '0;
  logic [1:0]    offSel = '0;
  logic [SW-1:0] shAmt = '0;
  logic [1:0]    mode = '0;
  logic          dirUp = 1'b1;
  logic [1:0]    size = '0;
  logic          signedLd = 1'b0;
  logic [31:0]   rdWord = '0;
  logic [AW-1:0] effAddr;
  logic          wbEn;
  logic [AW-1:0] wbVal;
  logic [31:0]   ldData;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  ldst_agu #(.ADDR_W(AW), .IMM_W(IW), .SH_W(SW)) u0 (
    .clk(clk), .rstN(rstN), .bigEndPin(bigEndPin), .base(base), .immOff(immOff),
    .idxReg(idxReg), .offSel(offSel), .shAmt(shAmt), .mode(mode), .dirUp(dirUp),
    .size(size), .signedLd(signedLd), .rdWord(rdWord), .effAddr(effAddr),
    .wbEn(wbEn), .wbVal(wbVal), .ldData(ldData)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doReset(input logic pin);
    @(negedge clk);
    rstN = 1'b0;
    bigEndPin = pin;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    bigEndPin = ~pin;  // must be ignored from here on
  endtask

  function automatic logic [31:0] expLoad(input logic [31:0] w, input int k,
                                          input int sz, input bit sgn, input bit big);
    int lane;
    logic [31:0] v;
    if (sz == 0) begin
      lane = big ? (3 - k) : k;
      v = (w >> (8 * lane)) & 32'hFF;
      if (sgn && v[7]) v = v | 32'hFFFF_FF00;
    end else if (sz == 1) begin
      lane = big ? (1 - (k >> 1)) : (k >> 1);
      v = (w >> (16 * lane)) & 32'hFFFF;
      if (sgn && v[15]) v = v | 32'hFFFF_0000;
    end else begin
      v = w;
    end
    return v;
  endfunction

  task automatic loadSweep(input bit big);
    logic [31:0] words [6] = '{32'h8081_7F02, 32'hF00F_55AA, 32'h0123_4567,
                               32'hFFFF_FFFF, 32'h0000_0000, 32'h7F80_80FF};
    for (int w = 0; w < 6; w++)
      for (int sz = 0; sz < 4; sz++)
        for (int sg = 0; sg < 2; sg++)
          for (int k = 0; k < 4; k++) begin
            string tag;
            @(negedge clk);
            mode = 2'd0; offSel = 2'd0; dirUp = 1'b1; base = AW'(32'h40);
            immOff = IW'(k); size = 2'(sz); signedLd = sg[0]; rdWord = words[w];
            #1;
            if (sz >= 2) tag = "R9";
            else if (big) tag = "R8";
            else if (sz == 1) tag = "R7";
            else if (sg == 1) tag = "R6";
            else tag = "R5";
            chk(tag, ldData, expLoad(words[w], k, sz, sg[0], big));
          end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int bases [4] = '{0, 5, MASK, 512};
    doReset(1'b0);

    // reset state with idle inputs (R1)
    @(negedge clk); #1;
    chk("R1 reset addr", 32'(effAddr), 32'h0);
    chk("R1 reset wb", 32'(wbEn), 32'h0);

    // address generation sweep: R1 R2 R3 R4
    for (int b = 0; b < 4; b++)
      for (int md = 0; md < 4; md++)
        for (int sel = 0; sel < 4; sel++)
          for (int dir = 0; dir < 2; dir++)
            for (int sh = 0; sh < 4; sh++)
              for (int im = 0; im < 16; im++) begin
                int off, sum, ea;
                int idx;
                string tag;
                idx = (im * 37 + 3 + b * 101) & MASK;
                @(negedge clk);
                base = AW'(bases[b]); mode = 2'(md); offSel = 2'(sel);
                dirUp = dir[0]; shAmt = SW'(sh); immOff = IW'(im); idxReg = AW'(idx);
                size = 2'd2;
                #1;
                if (sel == 0) off = im;
                else if (sel == 1) off = idx;
                else off = (idx << sh) & MASK;
                sum = dir ? ((bases[b] + off) & MASK) : ((bases[b] - off) & MASK);
                ea = (md == 2) ? bases[b] : sum;
                tag = (md == 1) ? "R2" : (md == 2) ? "R3" : "R1";
                chk({tag, " R4 ea"}, 32'(effAddr), 32'(ea));
                chk({tag, " wbEn"}, 32'(wbEn), (md == 1 || md == 2) ? 32'd1 : 32'd0);
                if (md == 1 || md == 2) chk({tag, " R4 wbVal"}, 32'(wbVal), 32'(sum));
              end

    // little-endian load formatting: R5 R6 R7 R9
    loadSweep(1'b0);

    // big-endian reset, pin toggled after release: R8
    doReset(1'b1);
    loadSweep(1'b1);
    @(negedge clk);
    mode = 2'd0; offSel = 2'd0; base = '0; immOff = '0; dirUp = 1'b1;
    size = 2'd0; signedLd = 1'b0; rdWord = 32'h1122_3344; bigEndPin = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    chk("R8 pin ignored after reset", ldData, 32'h11);

    // back to little-endian, pin raised after release
    doReset(1'b0);
    @(negedge clk);
    mode = 2'd0; offSel = 2'd0; base = '0; immOff = '0; dirUp = 1'b1;
    size = 2'd0; signedLd = 1'b0; rdWord = 32'h1122_3344;
    #1;
    chk("R8 little order latched", ldData, 32'h44);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule